// File: doc/BRIEF.md
# Daisy-Chained Status Clock Relay

This block sits in each device of a stack of battery monitors and carries a clocked health signal along the chain. An enable clock arrives from the device below. The block forwards it, registered, to the device above. It also watches that clock's rate. While the rate is high enough, the device counts as enabled.

A status clock returns from the device above. The block samples it a fixed delay after every enable edge and compares it with the enable level. When enough consecutive periods agree and the local stack is within limits, the status output becomes a copy of the enable clock. In every other case the status output rests low and its complement rests high. A healthy chain therefore shows up as a running clock at the bottom of the stack, not as a static level.

The status outputs change only at enable-clock edges, so no partial pulse appears in the middle of a period. The one exception is a loss of enable, which forces them low once the enable clock has already stopped. All inputs are single-ended, synchronous to the system clock, and sampled on its rising edge.

Top module: `status_chain_relay`

## Requirements
- R1: While `rst` is high, and at the first clock after it, `en_out` is 0, `stat_out` is 0, `stat_out_n` is 1 and `enabled` is 0.
- R2: `en_out` equals the value `en_in` had at the previous rising system-clock edge.
- R3: `enabled` becomes 1 at a rising enable edge that comes no more than MAX_PERIOD = CLK_HZ/MIN_EN_HZ system clocks after the previous rising edge. It returns to 0 once MAX_PERIOD clocks pass with no rising edge. A period of exactly MAX_PERIOD keeps it at 1, and a period of MAX_PERIOD+1 keeps it at 0.
- R4: SAMPLE_DLY system clocks after each enable edge, `stat_in` is compared with the enable level of that half period. A mismatch, such as an inverted, missing or late status clock, clears validity.
- R5: Validity returns only after GOOD_PERIODS consecutive matching samples taken in the high half of the enable clock. Until then `stat_out` stays 0.
- R6: While the block is valid, enabled and `stack_ok` is 1, `stat_out` follows `en_out` cycle for cycle.
- R7: In every other case, including `stack_ok` at 0 with a correct status clock, `stat_out` is 0 and `stat_out_n` is 1.
- R8: While enabled, `stat_out` changes only in the cycles where `en_out` changes.
- R9: `stat_out_n` is always the complement of `stat_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for measurement |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Sampled enable clock from the device below |
| stat_in | input | 1 | Status clock returned from the device above |
| stack_ok | input | 1 | Local stack within limits |
| en_out | output | 1 | Registered copy of the enable clock, sent up the chain |
| stat_out | output | 1 | True status line, a copy of the enable clock when healthy |
| stat_out_n | output | 1 | Complement status line |
| enabled | output | 1 | Enable clock fast enough |

## Verification
The rate monitor has two actions that can land on the same system-clock edge: a new rising enable edge and the expiry of the period limit. Both fall on that edge when the enable period is exactly MAX_PERIOD clocks. The bench provokes this with a 10-high, 10-low enable clock at a limit of 20, and judges that `enabled` never drops and that the status output keeps toggling. A 10-high, 11-low clock, one clock longer, must leave `enabled` at 0 and the status output held low.

// File: rtl/status_chain_pkg.sv
package status_chain_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } en_edge_t;
endpackage

// File: rtl/scr_freq_monitor.sv
module scr_freq_monitor
  import status_chain_pkg::*;
#(
  parameter int MAX_PERIOD = 50000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en_in,
  output logic     en_lvl,
  output en_edge_t evt,
  output logic     enabled
);
  localparam int CW = $clog2(MAX_PERIOD + 1);
  localparam logic [CW-1:0] MAXV = CW'(MAX_PERIOD);
  localparam logic [CW-1:0] LASTV = CW'(MAX_PERIOD - 1);

  logic [CW-1:0] since_rise;

  assign evt.rise = en_in & ~en_lvl;
  assign evt.fall = ~en_in & en_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_lvl     <= 1'b0;
      since_rise <= MAXV;
      enabled    <= 1'b0;
    end else begin
      en_lvl <= en_in;
      if (evt.rise) begin
        since_rise <= '0;
        enabled    <= (since_rise < MAXV);
      end else if (since_rise != MAXV) begin
        since_rise <= since_rise + CW'(1);
        if (since_rise == LASTV) enabled <= 1'b0;
      end
    end
  end

  // R3: enable can only appear on a rising enable edge
  p_enable_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(enabled) |-> $past(en_in && !en_lvl));

  // R3: a saturated counter means a stopped clock, never enabled
  p_timeout_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rise == MAXV) |-> !enabled);
endmodule

// File: rtl/scr_phase_checker.sv
module scr_phase_checker
  import status_chain_pkg::*;
#(
  parameter int SAMPLE_DLY   = 8,
  parameter int GOOD_PERIODS = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     en_lvl,
  input  en_edge_t evt,
  input  logic     enabled,
  input  logic     stat_in,
  output logic     valid
);
  localparam int DW = $clog2(SAMPLE_DLY + 1);
  localparam int GW = $clog2(GOOD_PERIODS + 1);
  localparam logic [DW-1:0] DLYV  = DW'(SAMPLE_DLY);
  localparam logic [GW-1:0] GOODV = GW'(GOOD_PERIODS);
  localparam logic [GW-1:0] PREV  = GW'(GOOD_PERIODS - 1);

  logic          armed;
  logic [DW-1:0] dly;
  logic [GW-1:0] good_cnt;
  logic          any_edge;
  logic          sample_now;
  logic          sample_ok;

  assign any_edge   = evt.rise | evt.fall;
  // a sample colliding with the next edge is dropped
  assign sample_now = armed && (dly == DLYV) && !any_edge;
  assign sample_ok  = (stat_in == en_lvl);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed    <= 1'b0;
      dly      <= '0;
      good_cnt <= '0;
      valid    <= 1'b0;
    end else begin
      if (any_edge) begin
        armed <= 1'b1;
        dly   <= DW'(1);
      end else if (armed) begin
        if (dly == DLYV) armed <= 1'b0;
        else             dly   <= dly + DW'(1);
      end

      if (!enabled) begin
        good_cnt <= '0;
        valid    <= 1'b0;
      end else if (sample_now) begin
        if (!sample_ok) begin
          good_cnt <= '0;
          valid    <= 1'b0;
        end else if (en_lvl) begin
          if (good_cnt != GOODV) good_cnt <= good_cnt + GW'(1);
          if (good_cnt >= PREV)  valid    <= 1'b1;
        end
      end
    end
  end

  // R4: a mismatching sample drops validity at the next edge
  p_mismatch_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_now && enabled && (stat_in != en_lvl)) |=> !valid);

  // R5: validity never survives a disabled cycle
  p_valid_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
    !enabled |=> !valid);

  // R5: validity only rises on a matching high-half sample
  p_valid_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(sample_now && en_lvl && stat_in));
endmodule

// File: rtl/scr_status_driver.sv
module scr_status_driver
  import status_chain_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en_in,
  input  en_edge_t evt,
  input  logic     valid,
  input  logic     enabled,
  input  logic     stack_ok,
  output logic     stat_out,
  output logic     stat_out_n
);
  logic pass;
  logic next_lvl;

  assign pass     = valid & stack_ok & enabled;
  assign next_lvl = pass & en_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_out   <= 1'b0;
      stat_out_n <= 1'b1;
    end else if (evt.rise | evt.fall) begin
      stat_out   <= next_lvl;
      stat_out_n <= ~next_lvl;
    end else if (!enabled) begin
      stat_out   <= 1'b0;
      stat_out_n <= 1'b1;
    end
  end

  // R9: the two status lines never agree
  p_complement_r9: assert property (@(posedge clk) disable iff (rst)
    stat_out != stat_out_n);

  // R8: a status change needs an enable edge or a lost enable
  p_change_on_edge_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_out) |-> ($past(evt.rise | evt.fall) || !$past(enabled)));

  // R7: an edge seen while not passing leaves the output low
  p_gate_low_r7: assert property (@(posedge clk) disable iff (rst)
    ((evt.rise | evt.fall) && !pass) |=> !stat_out);
endmodule

// File: rtl/status_chain_relay.sv
module status_chain_relay
  import status_chain_pkg::*;
#(
  parameter int CLK_HZ       = 100_000_000,
  parameter int MIN_EN_HZ    = 2000,
  parameter int SAMPLE_DLY   = 8,
  parameter int GOOD_PERIODS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_in,
  input  logic stat_in,
  input  logic stack_ok,
  output logic en_out,
  output logic stat_out,
  output logic stat_out_n,
  output logic enabled
);
  localparam int MAX_PERIOD = CLK_HZ / MIN_EN_HZ;

  en_edge_t evt;
  logic     en_lvl;
  logic     valid;

  scr_freq_monitor #(.MAX_PERIOD(MAX_PERIOD)) u_freq (
    .clk(clk), .rst(rst), .en_in(en_in),
    .en_lvl(en_lvl), .evt(evt), .enabled(enabled)
  );

  scr_phase_checker #(.SAMPLE_DLY(SAMPLE_DLY), .GOOD_PERIODS(GOOD_PERIODS)) u_phase (
    .clk(clk), .rst(rst), .en_lvl(en_lvl), .evt(evt),
    .enabled(enabled), .stat_in(stat_in), .valid(valid)
  );

  scr_status_driver u_drv (
    .clk(clk), .rst(rst), .en_in(en_in), .evt(evt), .valid(valid),
    .enabled(enabled), .stack_ok(stack_ok),
    .stat_out(stat_out), .stat_out_n(stat_out_n)
  );

  assign en_out = en_lvl;

  // R2: forwarded enable is the input one clock later
  p_en_copy_r2: assert property (@(posedge clk) disable iff (rst)
    en_out == $past(en_in));
endmodule

// File: tb/test_status_chain_relay.sv
`timescale 1ns/1ps
module test_status_chain_relay;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_in = 1'b0, stat_in = 1'b0, stack_ok = 1'b0;
  logic en_out, stat_out, stat_out_n, enabled;

  always #5 clk = ~clk;

  // limit = 1e6 / 5e4 = 20 clocks, sample 2 clocks after each edge, 3 good periods
  status_chain_relay #(.CLK_HZ(1_000_000), .MIN_EN_HZ(50_000),
                       .SAMPLE_DLY(2), .GOOD_PERIODS(3)) i_status_chain_relay (
    .clk(clk), .rst(rst), .en_in(en_in), .stat_in(stat_in), .stack_ok(stack_ok),
    .en_out(en_out), .stat_out(stat_out), .stat_out_n(stat_out_n), .enabled(enabled)
  );

  int checks = 0, failures = 0;
  int en_err, out_err, glitch, comp_err, seen_high;
  logic [3:0] hist = '0;
  logic prev_so = 1'b0, prev_eo = 1'b0;

  // modes: 0 copy, 1 late by one clock, 2 late by three clocks, 3 inverted, 4 stuck low
  // columns: hi, lo, mode, stack_ok, expected enabled, expected toggling
  localparam int VEC [12][6] = '{
    '{4, 4, 0, 1, 1, 1},
    '{4, 4, 1, 1, 1, 1},
    '{4, 4, 0, 0, 1, 0},
    '{4, 4, 0, 1, 1, 1},
    '{4, 4, 3, 1, 1, 0},
    '{4, 4, 2, 1, 1, 0},
    '{4, 4, 4, 1, 1, 0},
    '{4, 4, 0, 1, 1, 1},
    '{3, 5, 0, 1, 1, 1},
    '{10, 10, 0, 1, 1, 1},
    '{10, 11, 0, 1, 0, 0},
    '{6, 6, 0, 1, 1, 1}
  };

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run(input int hi, input int lo, input int mode, input bit ok,
                     input int nper, input int chk_from, input bit exp_en, input bit exp_tog);
    for (int p = 0; p < nper; p++) begin
      for (int c = 0; c < hi + lo; c++) begin
        logic lvl;
        @(negedge clk);
        if (stat_out_n !== ~stat_out) comp_err++;
        if (enabled === 1'b1 && stat_out !== prev_so && en_out === prev_eo) glitch++;
        if (stat_out === 1'b1) seen_high++;
        prev_so = stat_out;
        prev_eo = en_out;
        if (p >= chk_from) begin
          if (enabled !== exp_en) en_err++;
          if (exp_tog) begin
            if (stat_out !== en_out || stat_out_n !== ~en_out) out_err++;
          end else if (stat_out !== 1'b0 || stat_out_n !== 1'b1) out_err++;
        end
        lvl = (c < hi);
        hist = {hist[2:0], lvl};
        en_in = lvl;
        stack_ok = ok;
        case (mode)
          0: stat_in = lvl;
          1: stat_in = hist[1];
          2: stat_in = hist[3];
          3: stat_in = ~lvl;
          default: stat_in = 1'b0;
        endcase
      end
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    glitch = 0; comp_err = 0;
    repeat (3) @(negedge clk);
    check(en_out === 0 && stat_out === 0 && stat_out_n === 1 && enabled === 0,
          "R1 reset state", {en_out, stat_out, stat_out_n, enabled}, 4'b0010);
    rst = 1'b0;
    @(negedge clk);
    check(en_out === 0 && stat_out === 0 && stat_out_n === 1 && enabled === 0,
          "R1 first clock after reset", {en_out, stat_out, stat_out_n, enabled}, 4'b0010);

    // R2: forwarded one clock later
    en_in = 1'b1;
    #1 check(en_out === 1'b0, "R2 not yet forwarded", en_out, 0);
    @(negedge clk);
    check(en_out === 1'b1, "R2 forwarded after one clock", en_out, 1);
    en_in = 1'b0;
    @(negedge clk);
    check(en_out === 1'b0, "R2 low forwarded", en_out, 0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      en_err = 0; out_err = 0;
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3][0], 8, 6, VEC[i][4][0], VEC[i][5][0]);
      check(en_err == 0, $sformatf("R3 vector %0d enabled", i), en_err, 0);
      check(out_err == 0, $sformatf("%s vector %0d status", VEC[i][5] != 0 ? "R6" : "R7", i),
            out_err, 0);
    end

    // R5: after one inverted period, output stays low for three matching periods
    run(4, 4, 0, 1'b1, 8, 8, 1'b1, 1'b1);
    run(4, 4, 3, 1'b1, 1, 1, 1'b1, 1'b0);
    seen_high = 0;
    run(4, 4, 0, 1'b1, 3, 3, 1'b1, 1'b0);
    check(seen_high == 0, "R5 held low while regaining validity", seen_high, 0);
    en_err = 0; out_err = 0;
    run(4, 4, 0, 1'b1, 2, 0, 1'b1, 1'b1);
    check(out_err == 0, "R5 toggles once validity is back", out_err, 0);

    // R4: late status clock within a healthy stream drops it
    en_err = 0; out_err = 0;
    run(4, 4, 2, 1'b1, 3, 1, 1'b1, 1'b0);
    check(out_err == 0, "R4 late status clock held low", out_err, 0);

    // R3: stopped enable clock
    run(4, 4, 0, 1'b1, 8, 8, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    check(enabled === 1'b1, "R3 still enabled shortly after stop", enabled, 1);
    repeat (20) @(negedge clk);
    check(enabled === 1'b0, "R3 disabled after stop", enabled, 0);
    check(stat_out === 1'b0 && stat_out_n === 1'b1, "R7 stopped clock holds low",
          {stat_out, stat_out_n}, 2'b01);

    check(glitch == 0, "R8 status changed without enable edge", glitch, 0);
    check(comp_err == 0, "R9 complement mismatch", comp_err, 0);

    // R1: reset during activity
    run(4, 4, 0, 1'b1, 8, 8, 1'b1, 1'b1);
    rst = 1'b1;
    en_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(en_out === 0 && stat_out === 0 && stat_out_n === 1 && enabled === 0,
          "R1 reset mid-run", {en_out, stat_out, stat_out_n, enabled}, 4'b0010);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule